// File: doc/BRIEF.md
# Partition Real-Mode Address Translation Selector

This per-thread control unit sits in front of the address translation path of a processor that hosts logical partitions. For each memory access made by a partition it picks one of two routes. The first is a direct relocation: a base register is added to the address, and a length register checks that the address is in bounds. The second is a request to the page-table lookup logic, which carries a segment identifier and a page-size code. When that lookup reports a miss or a protection violation, the unit routes the fault either to the partition's operating system or to the hypervisor.

Two mode bits select the virtualised handling. One applies to accesses made with address translation off (real mode) and the other to accesses made with translation on. Under virtualised real mode, the access goes to the page table under a fixed, reserved segment identifier, and its page size comes from a configuration field. A force-small-page bit makes every translated access use 4-KB lookups. Faults routed to the hypervisor leave the faulting address, the access type and the real-mode flag in holding registers for the handler to read. The page-table walk itself lies outside the block and answers through a response code.

Top module: `xlat_route_top`

## Requirements
- R1: During and right after reset, `reqReady` is 1. `lkValid`, `doneValid` and `physValid` are 0, `fltCode` is 0, and the hypervisor holding registers are 0.
- R2: An access accepted with `reqXlatOn`=0, `cfgVirtReal`=0 and `reqAddr` < `cfgRealLimit` gives, in the next cycle, `doneValid`=1, `physValid`=1, `physAddr` = `cfgRealBase` + `reqAddr` (modulo 2^AW) and `fltCode`=0. It issues no lookup.
- R3: An access accepted with `reqXlatOn`=0 and `reqAddr` >= `cfgRealLimit` gives, in the next cycle, `doneValid`=1 and `fltCode`=3 (machine check), whatever `cfgVirtReal` holds. It issues no lookup and leaves `physValid` at 0.
- R4: An access accepted with `reqXlatOn`=0, `cfgVirtReal`=1 and in range raises a lookup one cycle later. The lookup carries `lkVsid` = parameter VSID_REAL and `lkPsz` = `cfgRealPsz`.
- R5: An access accepted with `reqXlatOn`=1 raises a lookup with `lkVsid` = `reqSegVsid`. `lkPsz` is 0 (4 KB) when `cfgForceSmall`=1 and `reqSegPsz` otherwise. No bounds check applies.
- R6: `lkAddr` is the request address with its in-page offset bits cleared. The page-size codes are 0=4 KB (12 bits), 1=64 KB (16 bits), 2=16 MB (24 bits) and 3=16 GB (34 bits). Codes 4 to 7 align as 4 KB.
- R7: `lkValid` stays high, with its fields unchanged, until the cycle in which `lkReady` is 1. `reqReady` is 0 from the acceptance of a lookup access until its response has been taken.
- R8: After the handshake, the first cycle with `rspValid`=1 ends the access, and `doneValid` follows one cycle later. `rspCode` 0 (hit) gives `fltCode`=0. Any other code (1 miss, 2 protection) gives `fltCode`=2 (hypervisor) if the mode bit for the access's real/translated kind was set at acceptance, and `fltCode`=1 (OS storage) otherwise. `rspValid` is ignored at any other time.
- R9: A hypervisor fault loads `hvAddr` (the unaligned request address), `hvStore` and `hvReal`. No other event changes them.
- R10: Each accepted access gives exactly one `doneValid` pulse, with at most one fault code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Unit can accept an access |
| reqAddr | input | AW | Logical/effective address |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqXlatOn | input | 1 | Address translation enabled for this access |
| reqSegPsz | input | 3 | Page-size code of the matching segment entry |
| reqSegVsid | input | VW | Segment identifier of the matching segment entry |
| cfgVirtReal | input | 1 | Virtualised handling for real-mode accesses |
| cfgVirtXlat | input | 1 | Virtualised handling for translated accesses |
| cfgForceSmall | input | 1 | Force 4-KB lookups for translated accesses |
| cfgRealPsz | input | 3 | Page-size code for virtualised real-mode lookups |
| cfgRealBase | input | AW | Real-mode relocation base |
| cfgRealLimit | input | AW | Real-mode area length in bytes |
| lkValid | output | 1 | Lookup request valid |
| lkReady | input | 1 | Lookup logic accepts the request |
| lkVsid | output | VW | Lookup segment identifier |
| lkPsz | output | 3 | Lookup page-size code |
| lkAddr | output | AW | Page-aligned lookup address |
| rspValid | input | 1 | Lookup result present |
| rspCode | input | 2 | 0 hit, 1 miss, 2 protection |
| doneValid | output | 1 | Access completed (one-cycle pulse) |
| physValid | output | 1 | `physAddr` holds a direct relocation result |
| physAddr | output | AW | Relocated physical address |
| fltCode | output | 2 | 0 none, 1 OS storage, 2 hypervisor, 3 machine check |
| hvAddr | output | AW | Address of the last hypervisor fault |
| hvStore | output | 1 | Access type of the last hypervisor fault |
| hvReal | output | 1 | Real-mode flag of the last hypervisor fault |

## Verification
The mode bits can change in the same cycle that a lookup response arrives, and also in the cycle that a request is accepted. The bench toggles `cfgVirtReal`, `cfgVirtXlat` and `cfgForceSmall` at random on many clock cycles while lookups are waiting, and it also raises `rspValid` spuriously while a lookup handshake is still pending. The reference model takes the routing bit and the page size only at acceptance and takes a response only in the waiting phase. A design that reads the live mode bits, or that takes an early response, differs from it in `fltCode` or in the holding registers.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_OS   = 2'd1,
    FLT_HV   = 2'd2,
    FLT_MCHK = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    PATH_DIRECT = 2'd0,
    PATH_RANGE  = 2'd1,
    PATH_LOOK   = 2'd2
  } path_e;

  typedef struct packed {
    logic takeDirect;
    logic takeLook;
    logic finishLook;
  } ctlStrobe_t;

  localparam int unsigned NUM_SIZES = 4;
  localparam logic [2:0] PSZ_4K = 3'd0;

  function automatic int unsigned pszShift(input logic [2:0] code);
    case (code)
      3'd1:    pszShift = 16;
      3'd2:    pszShift = 24;
      3'd3:    pszShift = 34;
      default: pszShift = 12;
    endcase
  endfunction

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  path_e      reqPath,
  input  logic       lkReady,
  input  logic       rspValid,
  output logic       reqReady,
  output logic       lkValid,
  output ctlStrobe_t strobe
);

  state_e state, stateNext;

  always_comb begin
    strobe = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqPath == PATH_LOOK) begin
            strobe.takeLook = 1'b1;
            stateNext = ST_LOOK;
          end else begin
            strobe.takeDirect = 1'b1;
          end
        end
      end
      ST_LOOK: if (lkReady) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (rspValid) begin
          strobe.finishLook = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign lkValid  = (state == ST_LOOK);

  // R7: a pending lookup is held until accepted
  a_r7_hold_lookup: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && !lkReady |=> lkValid);

  // R7: no new access while a lookup is outstanding
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> !reqReady);

  // R4: accepted lookup access raises lkValid next cycle
  a_r4_look_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqPath == PATH_LOOK |=> lkValid);

endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int unsigned AW = 48,
  parameter int unsigned VW = 24,
  parameter logic [VW-1:0] VSID_REAL = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] reqAddr,
  input  logic          reqStore,
  input  logic          reqXlatOn,
  input  logic [2:0]    reqSegPsz,
  input  logic [VW-1:0] reqSegVsid,
  input  logic          cfgVirtReal,
  input  logic          cfgVirtXlat,
  input  logic          cfgForceSmall,
  input  logic [2:0]    cfgRealPsz,
  input  logic [AW-1:0] cfgRealBase,
  input  logic [AW-1:0] cfgRealLimit,
  input  logic [1:0]    rspCode,
  input  ctlStrobe_t    strobe,
  output path_e         reqPath,
  output logic [VW-1:0] lkVsid,
  output logic [2:0]    lkPsz,
  output logic [AW-1:0] lkAddr,
  output logic          doneValid,
  output logic          physValid,
  output logic [AW-1:0] physAddr,
  output logic [1:0]    fltCode,
  output logic [AW-1:0] hvAddr,
  output logic          hvStore,
  output logic          hvReal
);

  localparam logic [AW-1:0] ALL_ONES = '1;

  logic          isReal;
  logic          inRange;
  logic [2:0]    selPsz;
  logic [VW-1:0] selVsid;
  logic          selVirt;
  logic [AW-1:0] alignCand [NUM_SIZES];
  logic [AW-1:0] selAligned;

  assign isReal  = !reqXlatOn;
  assign inRange = reqAddr < cfgRealLimit;

  always_comb begin
    if (isReal && !inRange)       reqPath = PATH_RANGE;
    else if (isReal && !cfgVirtReal) reqPath = PATH_DIRECT;
    else                          reqPath = PATH_LOOK;
  end

  assign selPsz  = isReal ? cfgRealPsz : (cfgForceSmall ? PSZ_4K : reqSegPsz);
  assign selVsid = isReal ? VSID_REAL : reqSegVsid;
  assign selVirt = isReal ? cfgVirtReal : cfgVirtXlat;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : gAlign
    assign alignCand[g] = reqAddr & (ALL_ONES << pszShift(3'(g)));
  end

  always_comb begin
    case (selPsz)
      3'd1:    selAligned = alignCand[1];
      3'd2:    selAligned = alignCand[2];
      3'd3:    selAligned = alignCand[3];
      default: selAligned = alignCand[0];
    endcase
  end

  // latched lookup context
  logic [AW-1:0] ctxFull;
  logic          ctxStore, ctxReal, ctxVirt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkVsid   <= '0;
      lkPsz    <= '0;
      lkAddr   <= '0;
      ctxFull  <= '0;
      ctxStore <= 1'b0;
      ctxReal  <= 1'b0;
      ctxVirt  <= 1'b0;
    end else if (strobe.takeLook) begin
      lkVsid   <= selVsid;
      lkPsz    <= selPsz;
      lkAddr   <= selAligned;
      ctxFull  <= reqAddr;
      ctxStore <= reqStore;
      ctxReal  <= isReal;
      ctxVirt  <= selVirt;
    end
  end

  // completion outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      physValid <= 1'b0;
      physAddr  <= '0;
      fltCode   <= FLT_NONE;
      hvAddr    <= '0;
      hvStore   <= 1'b0;
      hvReal    <= 1'b0;
    end else begin
      doneValid <= strobe.takeDirect | strobe.finishLook;
      physValid <= 1'b0;
      fltCode   <= FLT_NONE;
      if (strobe.takeDirect) begin
        if (reqPath == PATH_RANGE) begin
          fltCode <= FLT_MCHK;
        end else begin
          physValid <= 1'b1;
          physAddr  <= cfgRealBase + reqAddr;
        end
      end else if (strobe.finishLook && rspCode != 2'd0) begin
        if (ctxVirt) begin
          fltCode <= FLT_HV;
          hvAddr  <= ctxFull;
          hvStore <= ctxStore;
          hvReal  <= ctxReal;
        end else begin
          fltCode <= FLT_OS;
        end
      end
    end
  end

  // R10: any fault coincides with a completion pulse
  a_r10_fault_with_done: assert property (@(posedge clk) disable iff (!rstN)
    fltCode != FLT_NONE |-> doneValid);

  // R2: a relocated address never carries a fault
  a_r2_phys_clean: assert property (@(posedge clk) disable iff (!rstN)
    physValid |-> (fltCode == FLT_NONE) && doneValid);

  // R7: lookup fields only move when a new lookup is taken
  a_r7_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeLook |=> $stable(lkAddr) && $stable(lkVsid) && $stable(lkPsz));

  // R9: holding registers move only with a hypervisor fault
  a_r9_hv_hold: assert property (@(posedge clk) disable iff (!rstN)
    fltCode != FLT_HV |-> $stable(hvAddr) && $stable(hvStore) && $stable(hvReal));

endmodule

// File: rtl/xlat_route_top.sv
module xlat_route_top
  import xlat_pkg::*;
#(
  parameter int unsigned AW = 48,
  parameter int unsigned VW = 24,
  parameter logic [VW-1:0] VSID_REAL = '1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqAddr,
  input  logic          reqStore,
  input  logic          reqXlatOn,
  input  logic [2:0]    reqSegPsz,
  input  logic [VW-1:0] reqSegVsid,
  input  logic          cfgVirtReal,
  input  logic          cfgVirtXlat,
  input  logic          cfgForceSmall,
  input  logic [2:0]    cfgRealPsz,
  input  logic [AW-1:0] cfgRealBase,
  input  logic [AW-1:0] cfgRealLimit,
  output logic          lkValid,
  input  logic          lkReady,
  output logic [VW-1:0] lkVsid,
  output logic [2:0]    lkPsz,
  output logic [AW-1:0] lkAddr,
  input  logic          rspValid,
  input  logic [1:0]    rspCode,
  output logic          doneValid,
  output logic          physValid,
  output logic [AW-1:0] physAddr,
  output logic [1:0]    fltCode,
  output logic [AW-1:0] hvAddr,
  output logic          hvStore,
  output logic          hvReal
);

  ctlStrobe_t strobe;
  path_e      reqPath;

  xlat_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqPath  (reqPath),
    .lkReady  (lkReady),
    .rspValid (rspValid),
    .reqReady (reqReady),
    .lkValid  (lkValid),
    .strobe   (strobe)
  );

  xlat_dp #(.AW(AW), .VW(VW), .VSID_REAL(VSID_REAL)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .reqAddr       (reqAddr),
    .reqStore      (reqStore),
    .reqXlatOn     (reqXlatOn),
    .reqSegPsz     (reqSegPsz),
    .reqSegVsid    (reqSegVsid),
    .cfgVirtReal   (cfgVirtReal),
    .cfgVirtXlat   (cfgVirtXlat),
    .cfgForceSmall (cfgForceSmall),
    .cfgRealPsz    (cfgRealPsz),
    .cfgRealBase   (cfgRealBase),
    .cfgRealLimit  (cfgRealLimit),
    .rspCode       (rspCode),
    .strobe        (strobe),
    .reqPath       (reqPath),
    .lkVsid        (lkVsid),
    .lkPsz         (lkPsz),
    .lkAddr        (lkAddr),
    .doneValid     (doneValid),
    .physValid     (physValid),
    .physAddr      (physAddr),
    .fltCode       (fltCode),
    .hvAddr        (hvAddr),
    .hvStore       (hvStore),
    .hvReal        (hvReal)
  );

endmodule

// File: tb/sim_xlat_route_top.sv
`timescale 1ns/1ps
module sim_xlat_route_top;

  localparam int AW = 48;
  localparam int VW = 24;
  localparam logic [VW-1:0] RSV = 24'hABCDEF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          reqValid = 0, reqStore = 0, reqXlatOn = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [2:0]    reqSegPsz = '0;
  logic [VW-1:0] reqSegVsid = '0;
  logic          cfgVirtReal = 0, cfgVirtXlat = 0, cfgForceSmall = 0;
  logic [2:0]    cfgRealPsz = '0;
  logic [AW-1:0] cfgRealBase = 48'h0012_3450_0000;
  logic [AW-1:0] cfgRealLimit = 48'h0000_0800_0000;
  logic          lkReady = 0, rspValid = 0;
  logic [1:0]    rspCode = '0;

  logic          reqReady, lkValid, doneValid, physValid, hvStore, hvReal;
  logic [VW-1:0] lkVsid;
  logic [2:0]    lkPsz;
  logic [AW-1:0] lkAddr, physAddr, hvAddr;
  logic [1:0]    fltCode;

  xlat_route_top #(.AW(AW), .VW(VW), .VSID_REAL(RSV)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqStore(reqStore), .reqXlatOn(reqXlatOn),
    .reqSegPsz(reqSegPsz), .reqSegVsid(reqSegVsid),
    .cfgVirtReal(cfgVirtReal), .cfgVirtXlat(cfgVirtXlat),
    .cfgForceSmall(cfgForceSmall), .cfgRealPsz(cfgRealPsz),
    .cfgRealBase(cfgRealBase), .cfgRealLimit(cfgRealLimit),
    .lkValid(lkValid), .lkReady(lkReady), .lkVsid(lkVsid), .lkPsz(lkPsz),
    .lkAddr(lkAddr), .rspValid(rspValid), .rspCode(rspCode),
    .doneValid(doneValid), .physValid(physValid), .physAddr(physAddr),
    .fltCode(fltCode), .hvAddr(hvAddr), .hvStore(hvStore), .hvReal(hvReal)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int offBits(input logic [2:0] c);
    case (c)
      3'd1: return 16;
      3'd2: return 24;
      3'd3: return 34;
      default: return 12;
    endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  bit            mBusy, mLook, mVirt, mReal, mStore;
  bit            mDone, mPhysV;
  logic [1:0]    mFlt;
  logic [AW-1:0] mPhys, mLkAddr, mFull, mHvAddr;
  logic [VW-1:0] mVsid;
  logic [2:0]    mPsz;
  bit            mHvStore, mHvReal;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mLook = 0; mDone = 0; mPhysV = 0; mFlt = 0;
      mPhys = '0; mLkAddr = '0; mVsid = '0; mPsz = '0;
      mHvAddr = '0; mHvStore = 0; mHvReal = 0;
    end else begin
      mDone = 0; mPhysV = 0; mFlt = 0;
      if (!mBusy && reqValid) begin
        bit realAcc;
        realAcc = !reqXlatOn;
        if (realAcc && reqAddr >= cfgRealLimit) begin
          mDone = 1; mFlt = 2'd3;
        end else if (realAcc && !cfgVirtReal) begin
          mDone = 1; mPhysV = 1; mPhys = cfgRealBase + reqAddr;
        end else begin
          mBusy = 1; mLook = 1;
          mVsid = realAcc ? RSV : reqSegVsid;
          mPsz = realAcc ? cfgRealPsz : (cfgForceSmall ? 3'd0 : reqSegPsz);
          mLkAddr = (reqAddr >> offBits(mPsz)) << offBits(mPsz);
          mFull = reqAddr; mStore = reqStore; mReal = realAcc;
          mVirt = realAcc ? cfgVirtReal : cfgVirtXlat;
        end
      end else if (mLook) begin
        if (lkReady) mLook = 0;
      end else if (mBusy && rspValid) begin
        mBusy = 0; mDone = 1;
        if (rspCode != 2'd0) begin
          if (mVirt) begin
            mFlt = 2'd2; mHvAddr = mFull; mHvStore = mStore; mHvReal = mReal;
          end else begin
            mFlt = 2'd1;
          end
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        chk(reqReady == 1 && !lkValid && !doneValid && !physValid && fltCode == 0 && hvAddr == 0,
            "R1", "reset state", {reqReady, lkValid, doneValid, physValid, fltCode}, 64'h20);
      end else begin
        chk(reqReady == !mBusy, "R7", "reqReady", reqReady, !mBusy);
        chk(lkValid == mLook, "R7", "lkValid", lkValid, mLook);
        if (mLook) begin
          chk(lkVsid == mVsid, "R4", "lkVsid", lkVsid, mVsid);
          chk(lkPsz == mPsz, "R5", "lkPsz", lkPsz, mPsz);
          chk(lkAddr == mLkAddr, "R6", "lkAddr", lkAddr, mLkAddr);
        end
        chk(doneValid == mDone, "R10", "doneValid", doneValid, mDone);
        chk(physValid == mPhysV, "R2", "physValid", physValid, mPhysV);
        if (mPhysV) chk(physAddr == mPhys, "R2", "physAddr", physAddr, mPhys);
        if (mFlt == 2'd3) chk(fltCode == 2'd3, "R3", "machine check", fltCode, mFlt);
        else chk(fltCode == mFlt, "R8", "fltCode", fltCode, mFlt);
        chk(hvAddr == mHvAddr && hvStore == mHvStore && hvReal == mHvReal, "R9", "hv regs",
            {hvStore, hvReal, hvAddr}, {mHvStore, mHvReal, mHvAddr});
      end
    end
  end

  // ---------------- lookup responder and mode disturbance ----------------
  always @(negedge clk) begin
    if (rstN && !finished) begin
      lkReady  = ($urandom_range(0, 2) != 0);
      rspValid = (mBusy && !mLook) ? ($urandom_range(0, 2) != 0)
                                   : ($urandom_range(0, 5) == 0);
      rspCode  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) cfgVirtReal = ~cfgVirtReal;
      if ($urandom_range(0, 4) == 0) cfgVirtXlat = ~cfgVirtXlat;
      if ($urandom_range(0, 6) == 0) cfgForceSmall = ~cfgForceSmall;
      if ($urandom_range(0, 6) == 0) cfgRealPsz = 3'($urandom_range(0, 7));
    end
  end

  task automatic issue(input logic [AW-1:0] a, input bit st, input bit xl,
                       input logic [2:0] sp, input logic [VW-1:0] sv);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqAddr = a; reqStore = st; reqXlatOn = xl;
    reqSegPsz = sp; reqSegVsid = sv;
    @(negedge clk);
    reqValid = 0;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // boundary accesses in plain real mode
    cfgVirtReal = 0;
    issue(cfgRealLimit - 1, 0, 0, 0, 0);
    issue(cfgRealLimit, 1, 0, 0, 0);
    issue(48'h0, 0, 0, 0, 0);
    for (int i = 0; i < 1500; i++) begin
      logic [AW-1:0] a;
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = cfgRealLimit - 1;
        1: a = cfgRealLimit + 48'($urandom_range(0, 3));
        2: a = 48'($urandom_range(0, 32'h07FF_FFFF));
        default: a = {16'($urandom), 32'($urandom)};
      endcase
      issue(a, 1'($urandom), 1'($urandom), 3'($urandom_range(0, 7)), 24'($urandom));
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule